// File: doc/BRIEF.md
# Programmable-Phase Horizontal Drive Clock Generator

This block produces one horizontal drive clock for an image-sensor timing generator. It runs on a fast clock at eight times the pixel rate. A free-running sub-phase count splits every pixel period into eight slots, numbered 0 to 7. The drive output is set high in one programmable slot and cleared in another. The two slots are independent, so both the duty cycle and the position of the pulse within the pixel period can be placed on any eighth of a period.

While the vertical-shift indication is active, the output stops toggling and is held at a programmable level. Edge generation starts again only at a pixel-period boundary. All settings live in one 8-bit configuration register, which is written and read through a plain address/data port. A new setting is applied only at the start of the next pixel period, so a period already in progress is never cut short.

Top module: `hdrive_phase_gen`

## Requirements
- R1: After reset the output is low, and the configuration register at address 0x2C reads 0x1E (rise slot 6, fall slot 3, hold level low).
- R2: A write with address 0x2C updates the register, and the new value is readable in the cycle after the write. A write to any other address changes nothing. A read from any other address returns 0.
- R3: Bit 7 of the register always reads 0. The value written to bit 7 is discarded.
- R4: Bits 2:0 give the rise slot. On the clock edge where the sub-phase count equals that value, the output becomes high, unless the rise and fall slots are equal. In all other slots the output changes only through R5 or R7.
- R5: Bits 5:3 give the fall slot. On the clock edge where the sub-phase count equals that value, the output becomes low, unless the rise and fall slots are equal.
- R6: If the rise and fall slots are equal, the output keeps its previous level for the whole pixel period.
- R7: On every clock edge where the vertical-shift input is high, the output takes the level of bit 6 (0 = low, 1 = high). It keeps that level while vertical shift stays active.
- R8: A register write changes the output waveform only from the next pixel period on. That period starts at the edge that follows the count-7 edge. A write on the count-7 edge itself applies one period later.
- R9: After vertical shift goes low, the output stays at the hold level up to and including the next count-7 edge. From count 0 on, normal edge placement resumes.
- R10: The sub-phase count is 0 on the first edge after reset. It then advances by one on each fast-clock edge and wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock, eight times the pixel rate |
| rst_ni | input | 1 | Synchronous active-low reset |
| vshift_i | input | 1 | Vertical-shift indication; freezes the output while high |
| cfg_addr_i | input | 8 | Register address for reads and writes |
| cfg_wdata_i | input | 8 | Write data |
| cfg_wr_i | input | 1 | Write strobe, one fast-clock cycle per write |
| cfg_rdata_o | output | 8 | Read data for cfg_addr_i (combinational) |
| hclk_o | output | 1 | Horizontal drive clock |

## Verification
The hardest cases to reach from the ports are the ones that depend on where in the pixel period something happens. These are a write landing on the count-7 edge, and vertical shift dropping on different slots relative to the boundary where edge placement resumes. The bench walks writes and vertical-shift releases across different sub-phase slots, including slot 7. It uses settings with the rise in slot 7 and the fall in slot 0, and equal slots. A behavioural model, advanced on every clock, predicts the output and the read data cycle by cycle.

// File: rtl/hdrive_pkg.sv
// Package: shared types and default constants for the horizontal drive
// clock generator. Assumes nothing beyond IEEE 1800-2017 packages.
package hdrive_pkg;

    // Operating mode of the edge controller
    typedef enum logic {
        DRV_RUN  = 1'b0,   // edges placed from the rise/fall slots
        DRV_HOLD = 1'b1    // output frozen at the hold level
    } drv_mode_e;

    // Default geometry and register placement
    localparam int unsigned DEF_PHASE_W  = 3;
    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_ADDR_W   = 8;
    localparam logic [7:0]  DEF_CFG_ADDR = 8'h2C;
    localparam logic [7:0]  DEF_CFG_INIT = 8'h1E;

endpackage

// File: rtl/hdrive_phase_cnt.sv
// Module: sub-phase counter.
// Counts fast-clock cycles modulo 2**PHASE_W. Count value k is slot k of the
// pixel period. wrap_o marks the last slot, the edge that closes a period.
// Assumes: synchronous active-low reset, and the count is 0 on the first
// edge after reset.
module hdrive_phase_cnt #(
    parameter int unsigned PHASE_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    output logic [PHASE_W-1:0] cnt_o,
    output logic               wrap_o
);

    localparam logic [PHASE_W-1:0] LAST_SLOT = '1;
    localparam logic [PHASE_W-1:0] ONE_STEP  = PHASE_W'(1);

    logic [PHASE_W-1:0] cnt_q;

    // Advance the slot count once per fast clock
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE_STEP;
        end
    end

    // Expose the count and the end-of-period flag
    always_comb begin
        cnt_o  = cnt_q;
        wrap_o = (cnt_q == LAST_SLOT);
    end

endmodule

// File: rtl/hdrive_cfg_reg.sv
// Module: configuration register with a shadow copy and an active copy.
// The shadow copy is written and read through the address/data port. The
// active copy drives the edge logic and is loaded from the shadow on the
// last slot of each pixel period. Bits above the hold-level bit are not
// stored and read as zero.
// Assumes: DATA_W >= 2*PHASE_W+1. Field layout: rise slot in the low
// PHASE_W bits, fall slot in the next PHASE_W bits, hold level above them.
module hdrive_cfg_reg #(
    parameter int unsigned PHASE_W  = 3,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(8'h2C),
    parameter logic [DATA_W-1:0] CFG_INIT = DATA_W'(8'h1E)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               wr_i,
    input  logic               wrap_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [PHASE_W-1:0] rise_sel_o,
    output logic [PHASE_W-1:0] fall_sel_o,
    output logic               hold_lvl_o
);

    localparam int unsigned RISE_LO = 0;
    localparam int unsigned FALL_LO = PHASE_W;
    localparam int unsigned LVL_BIT = 2 * PHASE_W;

    logic              hit;
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] active_q;

    // Decode the single register address
    always_comb begin
        hit = (addr_i == CFG_ADDR);
    end

    // Per-bit storage: bits up to the hold level hold state, the rest are tied to zero
    for (genvar b = 0; b < int'(DATA_W); b++) begin : g_bit
        if (b <= int'(LVL_BIT)) begin : g_store
            // Shadow bit follows host writes; active bit reloads at the period boundary
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    shadow_q[b] <= CFG_INIT[b];
                    active_q[b] <= CFG_INIT[b];
                end else begin
                    if (wr_i && hit) begin
                        shadow_q[b] <= wdata_i[b];
                    end
                    if (wrap_i) begin
                        active_q[b] <= shadow_q[b];
                    end
                end
            end
        end else begin : g_tie
            // Unused bit position: constant zero
            always_comb begin
                shadow_q[b] = 1'b0;
                active_q[b] = 1'b0;
            end
        end
    end

    // Read mux and field extraction
    always_comb begin
        rdata_o    = hit ? shadow_q : '0;
        rise_sel_o = active_q[RISE_LO +: PHASE_W];
        fall_sel_o = active_q[FALL_LO +: PHASE_W];
        hold_lvl_o = active_q[LVL_BIT];
    end

endmodule

// File: rtl/hdrive_edge_ctl.sv
// Module: edge placement and hold control.
// In run mode the output goes high on the rise slot and low on the fall
// slot, and keeps its level if the two slots are equal. A high vertical-
// shift input forces the hold level and enters hold mode. Hold mode ends
// on the last slot of a period once vertical shift is low, so edges resume
// at slot 0.
// Assumes: slot settings change only at period boundaries (handled upstream).
module hdrive_edge_ctl
    import hdrive_pkg::*;
#(
    parameter int unsigned PHASE_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [PHASE_W-1:0] cnt_i,
    input  logic               wrap_i,
    input  logic [PHASE_W-1:0] rise_sel_i,
    input  logic [PHASE_W-1:0] fall_sel_i,
    input  logic               hold_lvl_i,
    input  logic               vshift_i,
    output logic               drv_o,
    output drv_mode_e          mode_o
);

    drv_mode_e mode_q, mode_d;
    logic      drv_q, drv_d;
    logic      slots_differ;

    // Work out the next output level and mode
    always_comb begin
        slots_differ = (rise_sel_i != fall_sel_i);
        mode_d       = mode_q;
        drv_d        = drv_q;
        unique case (mode_q)
            DRV_RUN: begin
                if (vshift_i) begin
                    drv_d  = hold_lvl_i;
                    mode_d = DRV_HOLD;
                end else if (slots_differ && (cnt_i == rise_sel_i)) begin
                    drv_d = 1'b1;
                end else if (slots_differ && (cnt_i == fall_sel_i)) begin
                    drv_d = 1'b0;
                end
            end
            DRV_HOLD: begin
                drv_d = hold_lvl_i;
                if (!vshift_i && wrap_i) begin
                    mode_d = DRV_RUN;
                end
            end
            default: begin
                mode_d = DRV_RUN;
            end
        endcase
    end

    // Register the drive level and the mode
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= DRV_RUN;
            drv_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            drv_q  <= drv_d;
        end
    end

    // Drive the outputs from the registers
    always_comb begin
        drv_o  = drv_q;
        mode_o = mode_q;
    end

endmodule

// File: rtl/hdrive_phase_gen.sv
// Module: top of the programmable-phase horizontal drive clock generator.
// Connects the sub-phase counter, the configuration register and the edge
// controller. Runs entirely in the fast (8x pixel) clock domain.
// Assumes: vshift_i and the register port are synchronous to clk_i.
module hdrive_phase_gen
    import hdrive_pkg::*;
#(
    parameter int unsigned PHASE_W  = DEF_PHASE_W,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(DEF_CFG_ADDR),
    parameter logic [DATA_W-1:0] CFG_INIT = DATA_W'(DEF_CFG_INIT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              vshift_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              cfg_wr_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    output logic              hclk_o
);

    logic [PHASE_W-1:0] cnt;
    logic               wrap;
    logic [PHASE_W-1:0] rise_sel;
    logic [PHASE_W-1:0] fall_sel;
    logic               hold_lvl;
    drv_mode_e          mode;

    hdrive_phase_cnt #(
        .PHASE_W (PHASE_W)
    ) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    hdrive_cfg_reg #(
        .PHASE_W  (PHASE_W),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .CFG_ADDR (CFG_ADDR),
        .CFG_INIT (CFG_INIT)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (cfg_addr_i),
        .wdata_i    (cfg_wdata_i),
        .wr_i       (cfg_wr_i),
        .wrap_i     (wrap),
        .rdata_o    (cfg_rdata_o),
        .rise_sel_o (rise_sel),
        .fall_sel_o (fall_sel),
        .hold_lvl_o (hold_lvl)
    );

    hdrive_edge_ctl #(
        .PHASE_W (PHASE_W)
    ) u_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cnt_i      (cnt),
        .wrap_i     (wrap),
        .rise_sel_i (rise_sel),
        .fall_sel_i (fall_sel),
        .hold_lvl_i (hold_lvl),
        .vshift_i   (vshift_i),
        .drv_o      (hclk_o),
        .mode_o     (mode)
    );

endmodule

// File: rtl/hdrive_phase_gen_chk.sv
// Module: assertion checker for hdrive_phase_gen, attached with bind.
// Observes the top-level ports and the signals passed between submodules.
module hdrive_phase_gen_chk
    import hdrive_pkg::*;
#(
    parameter int unsigned PHASE_W = 3,
    parameter int unsigned DATA_W  = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               vshift_i,
    input logic [DATA_W-1:0]  cfg_rdata_o,
    input logic               hclk_o,
    input logic [PHASE_W-1:0] cnt,
    input logic               wrap,
    input logic [PHASE_W-1:0] rise_sel,
    input logic [PHASE_W-1:0] fall_sel,
    input logic               hold_lvl,
    input drv_mode_e          mode
);

    localparam int unsigned LVL_BIT = 2 * PHASE_W;
    localparam logic [PHASE_W-1:0] ONE_STEP = PHASE_W'(1);

    // R3: bits above the hold level never read as one
    p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_rdata_o >> (LVL_BIT + 1)) == '0);

    // R4: rise slot in run mode drives the output high
    p_rise_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == DRV_RUN && !vshift_i && cnt == rise_sel && rise_sel != fall_sel) |=> hclk_o);

    // R4: outside both programmed slots the output keeps its level in run mode
    p_quiet_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == DRV_RUN && !vshift_i && cnt != rise_sel && cnt != fall_sel) |=> $stable(hclk_o));

    // R5: fall slot in run mode drives the output low
    p_fall_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == DRV_RUN && !vshift_i && cnt == fall_sel && rise_sel != fall_sel) |=> !hclk_o);

    // R6: equal slots leave the output unchanged
    p_equal_slots_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == DRV_RUN && !vshift_i && rise_sel == fall_sel) |=> $stable(hclk_o));

    // R7: vertical shift forces the hold level
    p_hold_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vshift_i |=> (hclk_o == $past(hold_lvl)));

    // R8: active settings change only at the period boundary
    p_cfg_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable({rise_sel, fall_sel, hold_lvl}));

    // R9: hold mode persists until the last slot of a period
    p_resume_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == DRV_HOLD && !wrap) |=> (mode == DRV_HOLD));

    // R10: the slot count steps by one every fast clock
    p_count_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (cnt == $past(cnt) + ONE_STEP));

endmodule

bind hdrive_phase_gen hdrive_phase_gen_chk #(
    .PHASE_W (PHASE_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vshift_i    (vshift_i),
    .cfg_rdata_o (cfg_rdata_o),
    .hclk_o      (hclk_o),
    .cnt         (cnt),
    .wrap        (wrap),
    .rise_sel    (rise_sel),
    .fall_sel    (fall_sel),
    .hold_lvl    (hold_lvl),
    .mode        (mode)
);

// File: tb/hdrive_phase_gen_tb_top.sv
// Bench: behavioural cycle model compared with the design on every clock.
module hdrive_phase_gen_tb_top;

    logic       clk;
    logic       rst_n;
    logic       vshift;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       wr;
    logic [7:0] rdata;
    logic       hclk;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    // Model state (plain integers)
    int m_cnt, m_shadow, m_act, m_out, m_hold;

    hdrive_phase_gen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .vshift_i    (vshift),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .cfg_wr_i    (wr),
        .cfg_rdata_o (rdata),
        .hclk_o      (hclk)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Behavioural model: advances on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_shadow = 'h1E; m_act = 'h1E; m_out = 0; m_hold = 0;
        end else begin
            int rs, fs, lvl, old_shadow;
            rs = m_act % 8;
            fs = (m_act / 8) % 8;
            lvl = (m_act / 64) % 2;
            old_shadow = m_shadow;
            if (m_hold == 0) begin
                if (vshift) begin
                    m_out = lvl; m_hold = 1;
                end else if (rs != fs && m_cnt == rs) m_out = 1;
                else if (rs != fs && m_cnt == fs) m_out = 0;
            end else begin
                m_out = lvl;
                if (!vshift && m_cnt == 7) m_hold = 0;
            end
            if (m_cnt == 7) m_act = old_shadow;
            if (wr && addr == 8'h2C) m_shadow = wdata & 'h7F;
            m_cnt = (m_cnt + 1) % 8;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare output and read data every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " hclk"}, int'(hclk), m_out);
            check({cur_req, " rdata"}, int'(rdata), (addr == 8'h2C) ? m_shadow : 0);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cyc(1);
        wr = 1'b0; addr = 8'h2C;
    endtask

    // Move to the slot after the edge where the count equals k
    task automatic to_slot(input int k);
        while (m_cnt != k) cyc(1);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; vshift = 1'b0; addr = 8'h2C; wdata = 8'h00; wr = 1'b0;
        cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset hclk", int'(hclk), 0);
        check("R1 reset value", int'(rdata), 'h1E);
        @(posedge clk); #1;

        cur_req = "R4,R5,R10 default slots";
        cyc(24);

        // R3: reserved bit dropped; R8: new slots apply next period
        cur_req = "R3,R8 write 0x85";
        to_slot(3);
        wr_reg(8'h2C, 8'h85);
        @(negedge clk);
        check("R3 reserved bit", int'(rdata), 'h05);
        @(posedge clk); #1;
        cyc(20);

        // R2: other address ignored and reads 0
        cur_req = "R2 other address";
        wr_reg(8'h2D, 8'h3F);
        addr = 8'h2D;
        @(negedge clk);
        check("R2 foreign read", int'(rdata), 0);
        @(posedge clk); #1;
        addr = 8'h2C;
        @(negedge clk);
        check("R2 unchanged after foreign write", int'(rdata), 'h05);
        @(posedge clk); #1;
        cyc(16);

        // R6: equal slots hold level, set while output is high and while low
        cur_req = "R6 equal slots";
        wr_reg(8'h2C, 8'h12);
        cyc(24);
        wr_reg(8'h2C, 8'h07);   // R4,R5 boundary: rise 7, fall 0
        cur_req = "R4,R5 rise7 fall0";
        cyc(24);
        wr_reg(8'h2C, 8'h3F);   // equal slots while output may be low
        cur_req = "R6 equal slots 7";
        cyc(24);

        // R8: write exactly on the count-7 edge
        cur_req = "R8 write on last slot";
        to_slot(7);
        wr_reg(8'h2C, 8'h0B);
        cyc(24);

        // R7, R9: hold high then release at several slots
        cur_req = "R7,R9 hold high";
        wr_reg(8'h2C, 8'h70);
        cyc(16);
        for (int k = 0; k < 8; k++) begin
            to_slot(k);
            vshift = 1'b1;
            cur_req = "R7 hold active";
            cyc(5 + k);
            vshift = 1'b0;
            cur_req = "R9 resume";
            cyc(13);
        end

        // R7, R9: hold low with a write during hold
        cur_req = "R7,R9 hold low";
        wr_reg(8'h2C, 8'h1D);
        cyc(10);
        to_slot(5);
        vshift = 1'b1;
        cyc(6);
        wr_reg(8'h2C, 8'h4A);
        cyc(9);
        vshift = 1'b0;
        cyc(24);

        // R1: reset restores the default
        cur_req = "R1 reset again";
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value again", int'(rdata), 'h1E);
        @(posedge clk); #1;
        cyc(16);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule